// File: doc/BRIEF.md
# Encoded SPI Serial Clock Generator

This block derives the serial clock of an SPI master from its parent clock. Software picks the bit rate with a 16-bit scaler code. One code passes the parent clock straight through. A small field selects a power-of-two divide from 2 to 32. Setting the prescaler field in the upper byte adds a further divide by 32, which reaches 64 to 1024. Any code outside that set falls back to the slowest ratio, divide-by-1024.

The clock pin rests at the polarity level whenever the clock is stopped. Polarity and phase together choose which pin transition samples incoming data and which one launches outgoing data. The sample transition is the rising one when polarity XOR (NOT phase) is 1. For each pin transition the block raises a one-cycle strobe, so the neighbouring shift logic can launch or sample in step with the pin.

The enable input starts and stops the clock. The rate code is captured only while the clock is stopped. When the enable is dropped in the middle of a clock period, the pin finishes its current half period and then returns to rest.

Top module: `spi_sck_gen`

## Requirements
- R1: While reset is asserted the pin equals the polarity input, and both strobes are 0.
- R2: Code 0x0007 is bypass. While enabled, the pin follows the parent clock (inverted when polarity is 1), and both strobes are 1 in every parent cycle.
- R3: With bits 15:8 equal to 0x00 and bits 7:0 equal to n (0 to 4), the pin changes level every 2^n parent cycles (ratio 2^(n+1)).
- R4: With bits 15:8 equal to 0x1F and bits 7:0 equal to n (0 to 4), the pin changes level every 2^(n+5) parent cycles (ratio 64 to 1024).
- R5: Any code not covered by R2 to R4 gives ratio 1024, so the pin changes level every 512 parent cycles.
- R6: While the enable is low and the pin is at rest, the pin holds the polarity level and no strobe is raised.
- R7: When polarity XOR (NOT phase) is 1, the sample strobe marks rising pin transitions and the launch strobe marks falling ones. When it is 0, the roles swap.
- R8: Outside bypass, each strobe is high for exactly the one parent cycle in which the pin first shows its new level, and both strobes are 0 in every other cycle.
- R9: A code change while the clock runs has no effect on the rate until the enable has been low with the pin at rest.
- R10: If the enable drops while the pin is away from its rest level, the pin makes exactly one more transition, back to rest, and then stays there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scaler_code | input | 16 | Encoded rate selection |
| cpol | input | 1 | Clock polarity; rest level of the pin |
| cpha | input | 1 | Clock phase; with polarity picks sample and launch edges |
| sck_en | input | 1 | Clock enable |
| sck | output | 1 | Serial clock pin |
| launch_stb | output | 1 | One-cycle strobe on the launching pin transition |
| sample_stb | output | 1 | One-cycle strobe on the sampling pin transition |

## Verification
The assertions assume two things: polarity and phase stay constant while the clock runs, and the enable only changes after the pin has settled at rest. The edge checks relate the strobes to the pin level, so a polarity change mid-run would invalidate them. The stimulus therefore changes the code, polarity and phase only with the enable low, and waits long enough for the pin to settle before enabling again. The one exception is the R9 test, which changes only the code while the clock runs, since that is the case being tested.

// File: rtl/spi_sck_pkg.sv
`timescale 1ns/1ps
package spi_sck_pkg;

  typedef struct packed {
    logic launch;
    logic sample;
  } sck_stb_t;

  // 1 selects the rising pin transition as the sampling edge
  function automatic logic sample_on_rise(input logic pol, input logic pha);
    return pol ^ ~pha;
  endfunction

endpackage

// File: rtl/sck_rate_decode.sv
`timescale 1ns/1ps
module sck_rate_decode #(
  parameter int CODE_W     = 16,
  parameter int FIELD_W    = 8,
  parameter int STEP_COUNT = 5,
  parameter int PRE_LOG    = 5,
  parameter int MAX_LOG    = 10,
  parameter int LOG_W      = 4,
  parameter logic [CODE_W-1:0]         BYPASS_CODE = 16'h0007,
  parameter logic [CODE_W-FIELD_W-1:0] PRE_SEL     = 8'h1F
) (
  input  logic [CODE_W-1:0] code,
  output logic [LOG_W-1:0]  ratio_log
);

  localparam int HI_W = CODE_W - FIELD_W;

  logic [HI_W-1:0]    hi_field;
  logic [FIELD_W-1:0] lo_field;
  logic               lo_ok;

  assign hi_field = code[CODE_W-1:FIELD_W];
  assign lo_field = code[FIELD_W-1:0];
  assign lo_ok    = (lo_field < FIELD_W'(STEP_COUNT));

  always_comb begin
    if (code == BYPASS_CODE) begin
      ratio_log = '0;
    end else if ((hi_field == '0) && lo_ok) begin
      ratio_log = LOG_W'(lo_field) + LOG_W'(1);
    end else if ((hi_field == PRE_SEL) && lo_ok) begin
      ratio_log = LOG_W'(lo_field) + LOG_W'(1 + PRE_LOG);
    end else begin
      ratio_log = LOG_W'(MAX_LOG);
    end
  end

endmodule

// File: rtl/sck_half_timer.sv
`timescale 1ns/1ps
module sck_half_timer #(
  parameter int LOG_W = 4,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LOG_W-1:0] ratio_log,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] term;

  // half period = 2^(ratio_log-1) parent cycles
  always_comb begin
    if (ratio_log == '0) begin
      term = '0;
    end else begin
      term = (CNT_W'(1) << (ratio_log - LOG_W'(1))) - CNT_W'(1);
    end
  end

  assign tick = run && (cnt_q == term);

  always_comb begin
    if (!run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sck_phase_ctl.sv
`timescale 1ns/1ps
module sck_phase_ctl
  import spi_sck_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sck_en,
  input  logic     cpol,
  input  logic     rise_samples,
  input  logic     bypass,
  input  logic     tick,
  output logic     ph_q,
  output logic     run,
  output logic     gate_n,
  output sck_stb_t stb_q
);

  logic     ph_d;
  logic     byp_run_q, byp_run_d;
  logic     new_pin;
  logic     is_sample_edge;
  sck_stb_t stb_d;

  assign run       = (sck_en | ph_q) & ~bypass;
  assign byp_run_d = sck_en & bypass;

  assign ph_d           = tick ? ~ph_q : ph_q;
  assign new_pin        = cpol ^ ~ph_q;
  assign is_sample_edge = (new_pin == rise_samples);

  always_comb begin
    stb_d.sample = gate_n | (tick & is_sample_edge);
    stb_d.launch = gate_n | (tick & ~is_sample_edge);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= 1'b0;
      byp_run_q <= 1'b0;
      stb_q     <= '0;
    end else begin
      ph_q      <= ph_d;
      byp_run_q <= byp_run_d;
      stb_q     <= stb_d;
    end
  end

  // gate for the pass-through clock changes only while the parent clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_n <= 1'b0;
    end else begin
      gate_n <= byp_run_q;
    end
  end

endmodule

// File: rtl/spi_sck_gen.sv
`timescale 1ns/1ps
module spi_sck_gen
  import spi_sck_pkg::*;
#(
  parameter int CODE_W     = 16,
  parameter int FIELD_W    = 8,
  parameter int STEP_COUNT = 5,
  parameter int PRE_LOG    = 5,
  parameter int MAX_LOG    = 10,
  parameter logic [CODE_W-1:0]         BYPASS_CODE = 16'h0007,
  parameter logic [CODE_W-FIELD_W-1:0] PRE_SEL     = 8'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] scaler_code,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              sck_en,
  output logic              sck,
  output logic              launch_stb,
  output logic              sample_stb
);

  localparam int LOG_W = $clog2(MAX_LOG + 1);
  localparam int CNT_W = (MAX_LOG > 1) ? MAX_LOG - 1 : 1;

  logic [1:0]       rst_pipe;
  logic             rst_core_n;
  logic [LOG_W-1:0] code_log;
  logic [LOG_W-1:0] lg_q, lg_d;
  logic             lg_load;
  logic             bypass;
  logic             ph_q;
  logic             run;
  logic             tick;
  logic             gate_n;
  sck_stb_t         stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  sck_rate_decode #(
    .CODE_W(CODE_W), .FIELD_W(FIELD_W), .STEP_COUNT(STEP_COUNT),
    .PRE_LOG(PRE_LOG), .MAX_LOG(MAX_LOG), .LOG_W(LOG_W),
    .BYPASS_CODE(BYPASS_CODE), .PRE_SEL(PRE_SEL)
  ) u_decode (
    .code      (scaler_code),
    .ratio_log (code_log)
  );

  // rate captured only while stopped and at rest
  assign lg_load = ~sck_en & ~ph_q;
  assign lg_d    = lg_load ? code_log : lg_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      lg_q <= LOG_W'(MAX_LOG);
    end else begin
      lg_q <= lg_d;
    end
  end

  assign bypass = (lg_q == '0);

  sck_half_timer #(.LOG_W(LOG_W), .CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run       (run),
    .ratio_log (lg_q),
    .tick      (tick)
  );

  sck_phase_ctl u_phase (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .sck_en       (sck_en),
    .cpol         (cpol),
    .rise_samples (sample_on_rise(cpol, cpha)),
    .bypass       (bypass),
    .tick         (tick),
    .ph_q         (ph_q),
    .run          (run),
    .gate_n       (gate_n),
    .stb_q        (stb_q)
  );

  assign sck        = cpol ^ (ph_q | (clk & gate_n));
  assign launch_stb = stb_q.launch;
  assign sample_stb = stb_q.sample;

endmodule

// File: rtl/spi_sck_gen_chk.sv
`timescale 1ns/1ps
module spi_sck_gen_chk #(
  parameter int LOG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sck_en,
  input logic             cpol,
  input logic             cpha,
  input logic             sck,
  input logic             launch_stb,
  input logic             sample_stb,
  input logic             ph_q,
  input logic [LOG_W-1:0] lg_q
);

  AST_SAMPLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !launch_stb) |-> (sck == (cpol ^ ~cpha))); // R7

  AST_LAUNCH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_stb && !sample_stb) |-> (sck != (cpol ^ ~cpha))); // R7

  AST_STROBE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_stb && !sample_stb) |=> !(launch_stb && !sample_stb)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_en && !$past(sck_en) && !ph_q) |=> (!launch_stb && !sample_stb)); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_en && !ph_q) |=> !ph_q); // R6

  AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sck_en) |-> $stable(lg_q)); // R9

endmodule

bind spi_sck_gen spi_sck_gen_chk #(.LOG_W(LOG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sck_en     (sck_en),
  .cpol       (cpol),
  .cpha       (cpha),
  .sck        (sck),
  .launch_stb (launch_stb),
  .sample_stb (sample_stb),
  .ph_q       (ph_q),
  .lg_q       (lg_q)
);

// File: tb/tb_spi_sck_gen.sv
`timescale 1ns/1ps
module tb_spi_sck_gen;

  logic        clk;
  logic        rst_n;
  logic [15:0] scaler_code;
  logic        cpol;
  logic        cpha;
  logic        sck_en;
  logic        sck;
  logic        launch_stb;
  logic        sample_stb;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  spi_sck_gen dut (
    .clk(clk), .rst_n(rst_n), .scaler_code(scaler_code),
    .cpol(cpol), .cpha(cpha), .sck_en(sck_en),
    .sck(sck), .launch_stb(launch_stb), .sample_stb(sample_stb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {code, cpol, cpha, bypass, log2 of half period}
  localparam int NV = 15;
  localparam logic [22:0] VEC [NV] = '{
    {16'h0007, 1'b0, 1'b0, 1'b1, 4'd0},  // R2 pass-through
    {16'h0000, 1'b0, 1'b0, 1'b0, 4'd0},  // R3 ratio 2
    {16'h0001, 1'b1, 1'b0, 1'b0, 4'd1},  // R3 ratio 4
    {16'h0002, 1'b0, 1'b1, 1'b0, 4'd2},  // R3 ratio 8
    {16'h0003, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 ratio 16
    {16'h0004, 1'b0, 1'b0, 1'b0, 4'd4},  // R3 ratio 32
    {16'h1F00, 1'b1, 1'b0, 1'b0, 4'd5},  // R4 ratio 64
    {16'h1F01, 1'b0, 1'b1, 1'b0, 4'd6},  // R4 ratio 128
    {16'h1F02, 1'b1, 1'b1, 1'b0, 4'd7},  // R4 ratio 256
    {16'h1F03, 1'b0, 1'b0, 1'b0, 4'd8},  // R4 ratio 512
    {16'h1F04, 1'b1, 1'b0, 1'b0, 4'd9},  // R4 ratio 1024
    {16'h0005, 1'b0, 1'b1, 1'b0, 4'd9},  // R5 low field out of range
    {16'h1F07, 1'b1, 1'b1, 1'b0, 4'd9},  // R5 prescaler with bad low field
    {16'h0107, 1'b0, 1'b0, 1'b0, 4'd9},  // R5 unknown upper byte
    {16'h0007, 1'b1, 1'b1, 1'b1, 4'd0}   // R2 pass-through, inverted
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic string rate_tag(input logic [15:0] c);
    if (c == 16'h0007) return "R2";
    if (c[15:8] == 8'h00 && c[7:0] < 8'd5) return "R3";
    if (c[15:8] == 8'h1F && c[7:0] < 8'd5) return "R4";
    return "R5";
  endfunction

  // sample after each rising parent edge; count pin transitions and check spacing and strobes
  task automatic measure(input int h, input int nedge, input string tag,
                         input logic pol, input logic pha);
    logic prev;
    logic esel;
    int   last;
    int   cyc;
    int   edges;
    esel  = pol ^ ~pha;
    @(posedge clk); #2;
    prev  = sck;
    last  = -1;
    cyc   = 0;
    edges = 0;
    while (edges < nedge && cyc < 8 * h + 40) begin
      @(posedge clk); #2;
      cyc++;
      if (sck !== prev) begin
        edges++;
        if (last >= 0) chk((cyc - last) == h, tag, cyc - last, h);
        chk(sample_stb === (sck == esel), "R7 sample", int'(sample_stb), int'(sck == esel));
        chk(launch_stb === (sck != esel), "R7 launch", int'(launch_stb), int'(sck != esel));
        last = cyc;
        prev = sck;
      end else begin
        chk(!launch_stb && !sample_stb, "R8 quiet", int'({launch_stb, sample_stb}), 0);
      end
    end
    chk(edges == nedge, {tag, " edge count"}, edges, nedge);
  endtask

  task automatic configure(input logic [15:0] c, input logic pol, input logic pha);
    @(negedge clk);
    sck_en      = 1'b0;
    scaler_code = c;
    cpol        = pol;
    cpha        = pha;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 180000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    rst_n       = 1'b0;
    scaler_code = 16'h0000;
    cpol        = 1'b0;
    cpha        = 1'b0;
    sck_en      = 1'b0;

    // R1 reset state, both polarities
    repeat (2) @(posedge clk);
    #2;
    chk(sck === 1'b0 && !launch_stb && !sample_stb, "R1 pol0",
        int'({sck, launch_stb, sample_stb}), 0);
    cpol = 1'b1;
    #1;
    chk(sck === 1'b1 && !launch_stb && !sample_stb, "R1 pol1",
        int'({sck, launch_stb, sample_stb}), 4);
    @(negedge clk);
    cpol  = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] c;
      logic        pol;
      logic        pha;
      logic        byp;
      int          h;
      c   = VEC[i][22:7];
      pol = VEC[i][6];
      pha = VEC[i][5];
      byp = VEC[i][4];
      h   = 1 << VEC[i][3:0];
      configure(c, pol, pha);
      // R6 stopped clock rests at polarity with no strobes
      for (int k = 0; k < 3; k++) begin
        @(posedge clk); #2;
        chk(sck === pol && !launch_stb && !sample_stb, "R6 idle",
            int'({sck, launch_stb, sample_stb}), int'({pol, 2'b00}));
      end
      @(negedge clk);
      sck_en = 1'b1;
      if (byp) begin
        repeat (3) @(posedge clk);
        for (int k = 0; k < 4; k++) begin
          @(posedge clk); #2;
          chk(sck === ~pol, "R2 high phase", int'(sck), int'(~pol));
          chk(launch_stb && sample_stb, "R2 strobes", int'({launch_stb, sample_stb}), 3);
          #4;
          chk(sck === pol, "R2 low phase", int'(sck), int'(pol));
        end
      end else begin
        measure(h, 4, rate_tag(c), pol, pha);
      end
      @(negedge clk);
      sck_en = 1'b0;
      repeat (2 * h + 4) @(negedge clk);
      chk(sck === pol, "R6 return to rest", int'(sck), int'(pol));
    end

    // R9: code change while running is ignored until stopped
    configure(16'h0000, 1'b0, 1'b0);
    @(negedge clk);
    sck_en = 1'b1;
    repeat (6) @(negedge clk);
    scaler_code = 16'h0004;
    measure(1, 4, "R9 running", 1'b0, 1'b0);
    @(negedge clk);
    sck_en = 1'b0;
    repeat (6) @(negedge clk);
    sck_en = 1'b1;
    measure(16, 3, "R9 after stop", 1'b0, 1'b0);
    @(negedge clk);
    sck_en = 1'b0;
    repeat (40) @(negedge clk);

    // R10: enable drop with pin away from rest
    configure(16'h0002, 1'b0, 1'b1);
    @(negedge clk);
    sck_en = 1'b1;
    for (int k = 0; k < 20 && sck !== 1'b1; k++) @(posedge clk);
    @(negedge clk);
    sck_en = 1'b0;
    begin
      int   changes;
      logic prev;
      changes = 0;
      prev    = sck;
      for (int k = 0; k < 30; k++) begin
        @(posedge clk); #2;
        if (sck !== prev) changes++;
        prev = sck;
      end
      chk(changes == 1, "R10 one closing edge", changes, 1);
      chk(sck === 1'b0, "R10 rest level", int'(sck), 0);
    end

    finish_up();
  end

endmodule